// File: doc/BRIEF.md
# Flash Status Register and Write-Permission Gate

This block keeps the status byte of a serial flash controller and decides, on every cycle, whether a program request aimed at a given sector may go ahead. It tracks three flags: a busy flag for array programming, a flag for data movement between the SRAM and the program buffer, and a write-enable latch. The controller's command decoder sends single-cycle strobes to set and clear the latch. The operation sequencer sends start and done pulses for programming and for buffer transfers.

Write protection is set by a four-bit range code and a direction bit. Together they define a boundary inside an 11-bit sector space. The boundary moves in steps of 0x80 sectors, and the direction bit selects which side of it is locked. The external write-protect pin, active low, stops the enable latch from being set. The write-allowed output combines the latch, the busy flag and the range decode. The flags are registered. The permission decode is combinational on the current flags and the target sector.

Top module: `flash_status_gate`

## Requirements
- R1: After reset, the status byte reads 0x00 and write_ok is 0.
- R2: Status bit 7 (busy) becomes 1 in the cycle after a prog_start pulse and returns to 0 in the cycle after a prog_done pulse. If both arrive in the same cycle, done wins.
- R3: Status bit 6 (transfer) becomes 1 after xfer_start and returns to 0 after xfer_done. Bit 7 reads 1 whenever bit 6 is 1.
- R4: Status bit 4 (write enable) is set in the cycle after cmd_wren while wp_n is 1, and cleared after cmd_wrdis. If both strobes arrive together, the latch ends at 0.
- R5: A cmd_wren strobe while wp_n is 0 has no effect, so the latch keeps its value.
- R6: With prot_range = 0, every sector 0x000–0x7FF is protected when prot_upper = 0, and no sector is protected when prot_upper = 1.
- R7: With prot_range = n (1..15), the boundary is B = 0x780 − n·0x80. With prot_upper = 0, sectors below B are protected. With prot_upper = 1, sectors from B through 0x7FF are protected.
- R8: write_ok is 1 only when bit 4 is 1, bit 7 is 0, and tgt_sector is outside the protected span.
- R9: Status bits 5 and 3..0 always read 0. Bit 0 is the compare-mismatch position and is tied to 0.
- R10: A prog_done pulse clears the write-enable bit in the next cycle, and it takes priority over cmd_wren in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdis | input | 1 | Write-disable command strobe |
| wp_n | input | 1 | Write-protect pin, low blocks enabling |
| prog_start | input | 1 | Array programming start pulse |
| prog_done | input | 1 | Array programming done pulse |
| xfer_start | input | 1 | SRAM/buffer transfer start pulse |
| xfer_done | input | 1 | SRAM/buffer transfer done pulse |
| prot_range | input | 4 | Protection range code |
| prot_upper | input | 1 | Direction: 1 locks the upper side of the boundary |
| tgt_sector | input | 11 | Sector targeted by a program request |
| status | output | 8 | Status byte |
| write_ok | output | 1 | Program request may proceed |

## Verification
The bench sweeps all sixteen range codes in both directions. For each, it probes sector 0, sector 0x7FF and the two sectors on either side of the boundary. A decoder that is off by one step, or that handles code 0 by the general formula, shows up here as a locked sector that should be free, or the reverse. Further scenarios pair colliding strobes: enable with disable, and done with enable. A design with the wrong priority leaves the latch set. Enabling with the protect pin low must keep the latch clear. A transfer alone must raise busy, and must also block writing to a sector that is otherwise open.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int STAT_W   = 8;
   localparam int BIT_BUSY = 7;
   localparam int BIT_XFER = 6;
   localparam int BIT_WEN  = 4;
   localparam int BIT_CMP  = 0;

   typedef struct packed {
      logic busy;
      logic xfer;
      logic wen;
   } fsr_flags_t;
endpackage

// File: rtl/fsr_flag_ctrl.sv
module fsr_flag_ctrl
   import fsr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wren,
   input  logic       cmd_wrdis,
   input  logic       wp_n,
   input  logic       prog_start,
   input  logic       prog_done,
   input  logic       xfer_start,
   input  logic       xfer_done,
   output fsr_flags_t flags
);
   logic prog_q, xfer_q, wen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= 1'b0;
      end else if (prog_done) begin
         prog_q <= 1'b0;
      end else if (prog_start) begin
         prog_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_q <= 1'b0;
      end else if (xfer_done) begin
         xfer_q <= 1'b0;
      end else if (xfer_start) begin
         xfer_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q <= 1'b0;
      end else if (prog_done || cmd_wrdis) begin
         wen_q <= 1'b0;
      end else if (cmd_wren && wp_n) begin
         wen_q <= 1'b1;
      end
   end

   always_comb begin
      flags.busy = prog_q | xfer_q;
      flags.xfer = xfer_q;
      flags.wen  = wen_q;
   end
endmodule

// File: rtl/fsr_range_decode.sv
module fsr_range_decode #(
   parameter int SECT_W  = 11,
   parameter int RANGE_W = 4
) (
   input  logic [RANGE_W-1:0] range_code,
   input  logic               upper,
   input  logic [SECT_W-1:0]  sector,
   output logic               locked
);
   localparam int STEP_SH = SECT_W - RANGE_W;
   localparam int NSTEP   = 1 << RANGE_W;
   localparam logic [RANGE_W-1:0] TOP_CODE = RANGE_W'(NSTEP - 1);

   generate
      if (RANGE_W < 1 || RANGE_W >= SECT_W) begin : g_bad_widths
         $error("fsr_range_decode: RANGE_W must be in 1..SECT_W-1");
      end
   endgenerate

   logic [SECT_W:0]  bound;
   logic [SECT_W:0]  sec_ext;
   logic [RANGE_W-1:0] steps;

   always_comb begin
      steps   = TOP_CODE - range_code;
      sec_ext = {1'b0, sector};
      if (range_code == '0) begin
         bound = (SECT_W+1)'(1) << SECT_W;
      end else begin
         bound = (SECT_W+1)'(steps) << STEP_SH;
      end
      locked = upper ? (sec_ext >= bound) : (sec_ext < bound);
   end
endmodule

// File: rtl/flash_status_gate.sv
module flash_status_gate
   import fsr_pkg::*;
#(
   parameter int SECT_W  = 11,
   parameter int RANGE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wren,
   input  logic               cmd_wrdis,
   input  logic               wp_n,
   input  logic               prog_start,
   input  logic               prog_done,
   input  logic               xfer_start,
   input  logic               xfer_done,
   input  logic [RANGE_W-1:0] prot_range,
   input  logic               prot_upper,
   input  logic [SECT_W-1:0]  tgt_sector,
   output logic [7:0]         status,
   output logic               write_ok
);
   generate
      if (STAT_W != 8) begin : g_bad_stat
         $error("flash_status_gate: status byte must be 8 bits");
      end
   endgenerate

   fsr_flags_t flags;
   logic       locked;

   fsr_flag_ctrl u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wren   (cmd_wren),
      .cmd_wrdis  (cmd_wrdis),
      .wp_n       (wp_n),
      .prog_start (prog_start),
      .prog_done  (prog_done),
      .xfer_start (xfer_start),
      .xfer_done  (xfer_done),
      .flags      (flags)
   );

   fsr_range_decode #(
      .SECT_W  (SECT_W),
      .RANGE_W (RANGE_W)
   ) u_range (
      .range_code (prot_range),
      .upper      (prot_upper),
      .sector     (tgt_sector),
      .locked     (locked)
   );

   generate
      for (genvar i = 0; i < STAT_W; i++) begin : g_stat
         if (i == BIT_BUSY) begin : g_busy
            assign status[i] = flags.busy;
         end else if (i == BIT_XFER) begin : g_xfer
            assign status[i] = flags.xfer;
         end else if (i == BIT_WEN) begin : g_wen
            assign status[i] = flags.wen;
         end else begin : g_zero
            assign status[i] = 1'b0;
         end
      end
   endgenerate

   assign write_ok = flags.wen & ~flags.busy & ~locked;
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wren,
   input logic       cmd_wrdis,
   input logic       wp_n,
   input logic       prog_done,
   input logic [7:0] status,
   input logic       write_ok
);
   AST_XFER_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      status[6] |-> status[7]); // R3
   AST_WRDIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wrdis |=> !status[4]); // R4
   AST_WP_BLOCKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren && !wp_n && !status[4]) |=> !status[4]); // R5
   AST_OK_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      write_ok |-> (status[4] && !status[7])); // R8
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status[5] == 1'b0) && (status[3:0] == 4'b0)); // R9
   AST_DONE_CLEARS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      prog_done |=> !status[4]); // R10
endmodule

bind flash_status_gate fsr_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wren  (cmd_wren),
   .cmd_wrdis (cmd_wrdis),
   .wp_n      (wp_n),
   .prog_done (prog_done),
   .status    (status),
   .write_ok  (write_ok)
);

// File: tb/tb_flash_status_gate.sv
`timescale 1ns/1ps
module tb_flash_status_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wren = 0, cmd_wrdis = 0, wp_n = 1;
   logic        prog_start = 0, prog_done = 0, xfer_start = 0, xfer_done = 0;
   logic [3:0]  prot_range = 0;
   logic        prot_upper = 0;
   logic [10:0] tgt_sector = 0;
   logic [7:0]  status;
   logic        write_ok;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   flash_status_gate dut (
      .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdis(cmd_wrdis),
      .wp_n(wp_n), .prog_start(prog_start), .prog_done(prog_done),
      .xfer_start(xfer_start), .xfer_done(xfer_done), .prot_range(prot_range),
      .prot_upper(prot_upper), .tgt_sector(tgt_sector), .status(status),
      .write_ok(write_ok)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit model_locked(int n, bit up, int sec);
      int b;
      b = (n == 0) ? 2048 : (15 - n) * 128;
      return up ? (sec >= b) : (sec < b);
   endfunction

   // one-cycle strobe, then sample after the registering edge
   task automatic strobe(input bit wen, input bit wdis, input bit ps, input bit pd,
                         input bit xs, input bit xd);
      @(negedge clk);
      cmd_wren = wen; cmd_wrdis = wdis; prog_start = ps; prog_done = pd;
      xfer_start = xs; xfer_done = xd;
      @(negedge clk);
      cmd_wren = 0; cmd_wrdis = 0; prog_start = 0; prog_done = 0;
      xfer_start = 0; xfer_done = 0;
      #1;
   endtask

   task automatic t_reset();
      #1;
      chk("R1 status", status, 8'h00);
      chk("R1 write_ok", write_ok, 0);
   endtask

   task automatic t_wen_wdis();
      wp_n = 1;
      strobe(1, 0, 0, 0, 0, 0);
      chk("R4 set", status, 8'h10);
      strobe(0, 1, 0, 0, 0, 0);
      chk("R4 clear", status, 8'h00);
      strobe(1, 0, 0, 0, 0, 0);
      strobe(1, 1, 0, 0, 0, 0);
      chk("R4 collide", status, 8'h00);
   endtask

   task automatic t_wp();
      wp_n = 0;
      strobe(1, 0, 0, 0, 0, 0);
      chk("R5 wp low", status, 8'h00);
      wp_n = 1;
      strobe(1, 0, 0, 0, 0, 0);
      wp_n = 0;
      strobe(1, 0, 0, 0, 0, 0);
      chk("R5 keep", status, 8'h10);
      wp_n = 1;
      strobe(0, 1, 0, 0, 0, 0);
   endtask

   task automatic t_prog();
      prot_range = 4'hF; prot_upper = 0; tgt_sector = 11'h100;
      strobe(1, 0, 0, 0, 0, 0);
      chk("R8 open", write_ok, 1);
      strobe(0, 0, 1, 0, 0, 0);
      chk("R2 busy", status, 8'h90);
      chk("R8 busy blocks", write_ok, 0);
      strobe(1, 0, 0, 1, 0, 0);
      chk("R10 done clears", status, 8'h00);
      strobe(0, 0, 1, 1, 0, 0);
      chk("R2 done wins", status, 8'h00);
   endtask

   task automatic t_xfer();
      strobe(1, 0, 0, 0, 0, 0);
      strobe(0, 0, 0, 0, 1, 0);
      chk("R3 xfer", status, 8'hD0);
      chk("R3 blocks write", write_ok, 0);
      strobe(0, 0, 0, 0, 0, 1);
      chk("R3 xfer done", status, 8'h10);
      chk("R9 unused", status & 8'h2F, 0);
   endtask

   task automatic t_ranges();
      for (int n = 0; n < 16; n++) begin
         for (int u = 0; u < 2; u++) begin
            int b;
            int secs[4];
            b = (n == 0) ? 2048 : (15 - n) * 128;
            secs[0] = 0; secs[1] = 2047;
            secs[2] = (b > 0) ? b - 1 : 0;
            secs[3] = (b < 2048) ? b : 2047;
            for (int k = 0; k < 4; k++) begin
               @(negedge clk);
               prot_range = 4'(n); prot_upper = u[0]; tgt_sector = 11'(secs[k]);
               #1;
               chk((n == 0) ? "R6 range" : "R7 range", write_ok,
                   model_locked(n, u[0], secs[k]) ? 0 : 1);
            end
         end
      end
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_wen_wdis();
      t_wp();
      t_prog();
      t_xfer();
      t_ranges();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule